// File: doc/BRIEF.md
# 9-bit UART receiver with break detect

This block recovers asynchronous serial frames from a single receive line. It uses a sampling tick that runs at sixteen times the bit rate. The top mode bit selects one of two frame lengths. In 8-bit frames the block receives a low start bit, eight data bits with the least significant bit first, and a stop bit. In 9-bit frames a ninth data bit sits between the last data bit and the stop bit. Each completed frame is presented on a valid/ready output stream as a byte plus one extra bit. In 9-bit frames the extra bit is the ninth data bit. In 8-bit frames it is the sampled stop bit. A one-cycle done strobe marks each frame the stream accepts.

The stream follows these back-pressure rules. While `m_valid` is high and `m_ready` is low, the byte and the extra bit are held unchanged. A frame that completes while the output register is still occupied and not being taken is discarded, and the held frame is kept. A frame completing in the same cycle as a handshake replaces the outgoing one.

Two sticky status flags run alongside the stream. The first records a framing error, meaning a stop bit sampled low. The second records a break, meaning the line held low for eleven bit times. Software clears each flag with its own clear strobe. A control-view output returns the two mode bits. When the remap control is set, the upper position shows the framing-error flag in place of the upper mode bit. When break-reset is enabled, a break raises a request to reset the device into a programming mode.

Top module: `uart9_rx`

## Requirements
- R1: After reset, `m_valid`, `rx_done`, `ferr_flag`, `brk_flag` and `rst_req` are 0, and `ctl_view` equals `mode` while `cfg_remap` is 0.
- R2: With `mode[1]`=1, a frame is 11 bits: start 0, data bits d0..d7, ninth bit, stop. The frame is delivered as `m_data`=d7..d0, with `m_bit9` set to the ninth bit.
- R3: With `mode[1]`=0, a frame is 10 bits: start, d0..d7, stop. The frame is delivered with `m_bit9` set to the sampled stop bit.
- R4: A start edge is confirmed by the sample at oversample count 8, counting the detecting tick as count 0. If that sample is high, the start is dropped and no frame is produced.
- R5: Each data bit, the ninth bit and the stop bit take the majority of samples 7, 8 and 9 of their bit period. A single flipped sample has no effect, and two flipped samples invert the bit.
- R6: A stop bit decided low sets the sticky `ferr_flag`, and the frame is still delivered. A one-cycle `clr_ferr` returns the flag to 0. Frames with a high stop bit never set it.
- R7: `ctl_view[0]` is `mode[0]`. `ctl_view[1]` is `ferr_flag` when `cfg_remap`=1, and `mode[1]` when `cfg_remap`=0.
- R8: `brk_flag` sets after 176 consecutive low ticks, which is 11 bit times of 16 ticks; 175 are not enough. Any high tick restarts the count. A continuous low level raises the flag only once, so after `clr_brk` it stays 0 until the line has gone high and then low for another 176 ticks.
- R9: `rst_req` is high exactly while `brk_flag` and `brk_rst_en` are both 1.
- R10: The output follows the valid/ready rules above, and `rx_done` pulses for one cycle when a frame is loaded into the output register.
- R11: Reception advances only on cycles with `os_tick` high. With the tick stopped, no frame is produced. With one tick every third cycle, frames of triple length are received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling tick, 16 per bit |
| rxd | input | 1 | Serial receive line, idle high |
| mode | input | 2 | Mode bits; bit 1 selects 9-bit frames |
| cfg_remap | input | 1 | Show framing error in the upper view position |
| brk_rst_en | input | 1 | Allow a break to request a reset |
| clr_ferr | input | 1 | Clear strobe for the framing-error flag |
| clr_brk | input | 1 | Clear strobe for the break flag |
| m_valid | output | 1 | Received frame available |
| m_ready | input | 1 | Consumer takes the frame |
| m_data | output | 8 | Received byte |
| m_bit9 | output | 1 | Ninth bit, or stop bit in 8-bit frames |
| rx_done | output | 1 | One-cycle strobe on frame load |
| ferr_flag | output | 1 | Sticky framing error |
| brk_flag | output | 1 | Sticky break detected |
| ctl_view | output | 2 | Mode bits with optional flag remap |
| rst_req | output | 1 | Reset request raised by a break |

## Verification
Four behaviours are checked by assertions on every cycle. The stream output must hold steady under back-pressure, and the done strobe must come only with valid data. The flags may rise only from a low stop decision or from a low line, and a clear strobe is the only way a flag falls. The reset request may never appear without the break flag, and the break event must stay a single pulse.

The remaining behaviours can only be shown by the bench's scenarios. These are the bit ordering and ninth-bit placement over every byte value in both frame lengths, the majority vote against one or two corrupted samples, and the start-glitch boundary at 8 versus 9 low samples. The bench also covers the break threshold at 175 versus 176 low ticks, and dropping a frame while the output register is occupied.

// File: rtl/uart9_rx_pkg.sv
package uart9_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_BITS,
    RX_STOP
  } rx_state_e;

  // Majority of three samples
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uart9_rx_sync.sv
module uart9_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign dout = din;
    end else begin : g_ff
      logic [STAGES-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '1;
        end else begin
          q[0] <= din;
          for (int i = 1; i < STAGES; i++) q[i] <= q[i-1];
        end
      end
      assign dout = q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/uart9_rx_framer.sv
module uart9_rx_framer
  import uart9_rx_pkg::*;
#(
  parameter int OS = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  input  logic          nine,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          bit9,
  output logic          stop_ok
);

  localparam int CW = $clog2(OS);
  localparam int IW = $clog2(DW + 1);
  localparam logic [CW-1:0] C_PRE  = CW'(OS / 2 - 1);
  localparam logic [CW-1:0] C_MID  = CW'(OS / 2);
  localparam logic [CW-1:0] C_POST = CW'(OS / 2 + 1);
  localparam logic [CW-1:0] C_LAST = CW'(OS - 1);
  localparam logic [IW-1:0] I_END8 = IW'(DW - 1);
  localparam logic [IW-1:0] I_END9 = IW'(DW);

  rx_state_e      st;
  logic [CW-1:0]  cnt;
  logic [IW-1:0]  idx;
  logic [DW:0]    shr;
  logic           s_pre, s_mid;
  logic           bitv;

  assign bitv = vote3(s_pre, s_mid, rxd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= RX_IDLE;
      cnt     <= '0;
      idx     <= '0;
      shr     <= '0;
      s_pre   <= 1'b1;
      s_mid   <= 1'b1;
      done    <= 1'b0;
      data    <= '0;
      bit9    <= 1'b0;
      stop_ok <= 1'b1;
    end else begin
      done <= 1'b0;
      if (tick) begin
        unique case (st)
          RX_IDLE: begin
            if (!rxd) begin
              st  <= RX_START;
              cnt <= CW'(1);
            end
          end
          RX_START: begin
            if (cnt == C_MID && rxd) begin
              st <= RX_IDLE;
            end else if (cnt == C_LAST) begin
              st  <= RX_BITS;
              cnt <= '0;
              idx <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_BITS, RX_STOP: begin
            cnt <= cnt + 1'b1;
            if (cnt == C_PRE) s_pre <= rxd;
            if (cnt == C_MID) s_mid <= rxd;
            if (st == RX_STOP) begin
              if (cnt == C_POST) begin
                done    <= 1'b1;
                data    <= shr[DW-1:0];
                bit9    <= nine ? shr[DW] : bitv;
                stop_ok <= bitv;
                st      <= RX_IDLE;
              end
            end else begin
              if (cnt == C_POST) shr[idx] <= bitv;
              if (cnt == C_LAST) begin
                cnt <= '0;
                if (idx == (nine ? I_END9 : I_END8)) st <= RX_STOP;
                else idx <= idx + 1'b1;
              end
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/uart9_rx_brk.sv
module uart9_rx_brk #(
  parameter int OS   = 16,
  parameter int BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rxd,
  output logic evt
);

  localparam int LIM = OS * BITS;
  localparam int BW  = $clog2(LIM + 1);
  localparam logic [BW-1:0] C_LIM = BW'(LIM);
  localparam logic [BW-1:0] C_ARM = BW'(LIM - 1);

  logic [BW-1:0] lows;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lows <= '0;
      evt  <= 1'b0;
    end else begin
      evt <= 1'b0;
      if (tick) begin
        if (rxd) begin
          lows <= '0;
        end else if (lows != C_LIM) begin
          lows <= lows + 1'b1;
          if (lows == C_ARM) evt <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/uart9_rx.sv
module uart9_rx #(
  parameter int OS          = 16,
  parameter int DW          = 8,
  parameter int BRK_BITS    = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic          rxd,
  input  logic [1:0]    mode,
  input  logic          cfg_remap,
  input  logic          brk_rst_en,
  input  logic          clr_ferr,
  input  logic          clr_brk,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data,
  output logic          m_bit9,
  output logic          rx_done,
  output logic          ferr_flag,
  output logic          brk_flag,
  output logic [1:0]    ctl_view,
  output logic          rst_req
);

  logic          rx_s;
  logic          fr_done;
  logic [DW-1:0] fr_data;
  logic          fr_bit9;
  logic          fr_stop;
  logic          brk_evt;
  logic          accept;

  uart9_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
  );

  uart9_rx_framer #(.OS(OS), .DW(DW)) u_frm (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rxd(rx_s), .nine(mode[1]),
    .done(fr_done), .data(fr_data), .bit9(fr_bit9), .stop_ok(fr_stop)
  );

  uart9_rx_brk #(.OS(OS), .BITS(BRK_BITS)) u_brk (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rxd(rx_s), .evt(brk_evt)
  );

  assign accept = fr_done && (!m_valid || m_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_bit9  <= 1'b0;
      rx_done <= 1'b0;
    end else begin
      rx_done <= accept;
      if (accept) begin
        m_valid <= 1'b1;
        m_data  <= fr_data;
        m_bit9  <= fr_bit9;
      end else if (m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ferr_flag <= 1'b0;
      brk_flag  <= 1'b0;
    end else begin
      if (fr_done && !fr_stop) ferr_flag <= 1'b1;
      else if (clr_ferr)       ferr_flag <= 1'b0;
      if (brk_evt)             brk_flag  <= 1'b1;
      else if (clr_brk)        brk_flag  <= 1'b0;
    end
  end

  assign ctl_view = {cfg_remap ? ferr_flag : mode[1], mode[0]};
  assign rst_req  = brk_flag & brk_rst_en;

endmodule

// File: rtl/uart9_rx_chk.sv
module uart9_rx_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          m_valid,
  input logic          m_ready,
  input logic [DW-1:0] m_data,
  input logic          m_bit9,
  input logic          rx_done,
  input logic          ferr_flag,
  input logic          brk_flag,
  input logic          rst_req,
  input logic          clr_ferr,
  input logic          rx_s,
  input logic          fr_done,
  input logic          fr_stop,
  input logic          brk_evt
);

  // R10
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_bit9)));

  // R10
  done_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> m_valid);

  // R6
  ferr_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ferr_flag) |-> $past(fr_done && !fr_stop));

  // R6
  ferr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ferr_flag) |-> $past(clr_ferr));

  // R8
  brk_low_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_flag) |-> !$past(rx_s, 2));

  // R8
  brk_single_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> !brk_evt);

  // R9
  rst_req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> brk_flag);

endmodule

bind uart9_rx uart9_rx_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready),
  .m_data(m_data), .m_bit9(m_bit9), .rx_done(rx_done),
  .ferr_flag(ferr_flag), .brk_flag(brk_flag), .rst_req(rst_req),
  .clr_ferr(clr_ferr), .rx_s(rx_s), .fr_done(fr_done),
  .fr_stop(fr_stop), .brk_evt(brk_evt)
);

// File: tb/sim_uart9_rx.sv
module sim_uart9_rx;

  localparam int CLK_P = 10;
  localparam int OS    = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick;
  logic       rxd = 1'b1;
  logic [1:0] mode = 2'b11;
  logic       cfg_remap = 1'b0;
  logic       brk_rst_en = 1'b0;
  logic       clr_ferr = 1'b0;
  logic       clr_brk = 1'b0;
  logic       m_ready = 1'b1;
  logic       m_valid;
  logic [7:0] m_data;
  logic       m_bit9;
  logic       rx_done;
  logic       ferr_flag;
  logic       brk_flag;
  logic [1:0] ctl_view;
  logic       rst_req;

  int  tdiv = 1;
  bit  tick_en = 1'b1;
  int  tcnt = 0;
  int  vectors = 0;
  int  miscompares = 0;
  bit  finished = 1'b0;
  int  got_cnt = 0;
  int  done_cnt = 0;
  logic [7:0] got_data = '0;
  logic       got_b9 = 1'b0;

  uart9_rx u0 (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd), .mode(mode),
    .cfg_remap(cfg_remap), .brk_rst_en(brk_rst_en), .clr_ferr(clr_ferr),
    .clr_brk(clr_brk), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_bit9(m_bit9), .rx_done(rx_done), .ferr_flag(ferr_flag),
    .brk_flag(brk_flag), .ctl_view(ctl_view), .rst_req(rst_req)
  );

  always #(CLK_P / 2) clk = ~clk;

  always @(posedge clk) tcnt <= (tcnt + 1 >= tdiv) ? 0 : tcnt + 1;
  assign os_tick = tick_en && (tcnt == 0);

  // stream monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (m_valid && m_ready) begin
      got_cnt++;
      got_data = m_data;
      got_b9   = m_bit9;
    end
    if (rx_done) done_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [8:0] v, input bit nine, input bit stopv,
                            input int fbit, input int nflip);
    int nb;
    int bitc;
    nb   = nine ? 11 : 10;
    bitc = OS * tdiv;
    for (int k = 0; k < nb; k++) begin
      logic val;
      if (k == 0) val = 1'b0;
      else if (k == nb - 1) val = stopv;
      else val = v[k-1];
      for (int c = 0; c < bitc; c++) begin
        rxd = ((k == fbit) && (c == 8 || (nflip == 2 && c == 7))) ? ~val : val;
        @(negedge clk);
      end
    end
    rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic line_for(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr(input bit which_brk);
    @(posedge clk);
    #(CLK_P / 4);
    if (which_brk) clr_brk = 1'b1; else clr_ferr = 1'b1;
    @(posedge clk);
    #(CLK_P / 4);
    clr_brk  = 1'b0;
    clr_ferr = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_ready(input logic r);
    @(posedge clk);
    #(CLK_P / 4);
    m_ready = r;
    @(negedge clk);
  endtask

  initial begin
    int p;
    int d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 m_valid", m_valid, 0);
    chk("R1 rx_done", rx_done, 0);
    chk("R1 ferr_flag", ferr_flag, 0);
    chk("R1 brk_flag", brk_flag, 0);
    chk("R1 rst_req", rst_req, 0);
    chk("R1 ctl_view", ctl_view, 3);

    // R2 sweep of all bytes in 9-bit frames, ninth bit = parity of byte
    mode = 2'b11;
    for (int b = 0; b < 256; b++) begin
      p = got_cnt;
      send_frame({^b[7:0], b[7:0]}, 1'b1, 1'b1, -1, 0);
      chk("R2 count", got_cnt, p + 1);
      chk("R2 frame", {got_b9, got_data}, {^b[7:0], b[7:0]});
    end
    chk("R6 no ferr on good stops", ferr_flag, 0);

    // R3 sweep in 8-bit frames, extra bit carries the stop bit
    mode = 2'b01;
    for (int b = 0; b < 256; b++) begin
      p = got_cnt;
      send_frame({1'b0, b[7:0]}, 1'b0, 1'b1, -1, 0);
      chk("R3 count", got_cnt, p + 1);
      chk("R3 frame", {got_b9, got_data}, {1'b1, b[7:0]});
    end

    // R6 framing error
    p = got_cnt;
    send_frame(9'h05A, 1'b0, 1'b0, -1, 0);
    chk("R6 delivered", got_cnt, p + 1);
    chk("R6 frame", {got_b9, got_data}, 9'h05A);
    chk("R6 flag set", ferr_flag, 1);

    // R7 view with flag set, then cleared
    for (int f = 1; f >= 0; f--) begin
      for (int r = 0; r < 2; r++) begin
        for (int m = 0; m < 4; m++) begin
          cfg_remap = r[0];
          mode = m[1:0];
          #1;
          chk("R7 view", ctl_view, {(r != 0) ? f[0] : m[1], m[0]});
        end
      end
      if (f == 1) begin
        pulse_clr(1'b0);
        chk("R6 flag cleared", ferr_flag, 0);
      end
    end
    cfg_remap = 1'b0;
    mode = 2'b11;
    @(negedge clk);

    // R4 start confirmation boundary
    p = got_cnt;
    line_for(1'b0, 8);
    line_for(1'b1, 220);
    chk("R4 glitch of 8 dropped", got_cnt, p);
    line_for(1'b0, 9);
    line_for(1'b1, 220);
    chk("R4 start of 9 accepted", got_cnt, p + 1);
    chk("R4 frame", {got_b9, got_data}, 9'h1FF);

    // R5 majority vote
    send_frame(9'h000, 1'b1, 1'b1, 4, 1);
    chk("R5 one flip data", {got_b9, got_data}, 9'h000);
    send_frame(9'h000, 1'b1, 1'b1, 4, 2);
    chk("R5 two flips data", {got_b9, got_data}, 9'h008);
    send_frame(9'h1FF, 1'b1, 1'b1, 9, 1);
    chk("R5 one flip ninth", {got_b9, got_data}, 9'h1FF);
    send_frame(9'h1FF, 1'b1, 1'b1, 9, 2);
    chk("R5 two flips ninth", {got_b9, got_data}, 9'h0FF);
    send_frame(9'h000, 1'b1, 1'b1, 10, 1);
    chk("R5 one flip stop", ferr_flag, 0);

    // R11 tick gating
    p = got_cnt;
    tick_en = 1'b0;
    send_frame(9'h011, 1'b1, 1'b1, -1, 0);
    tick_en = 1'b1;
    line_for(1'b1, 50);
    chk("R11 no tick no frame", got_cnt, p);
    tdiv = 3;
    line_for(1'b1, 10);
    send_frame(9'h0A5, 1'b1, 1'b1, -1, 0);
    chk("R11 slow tick count", got_cnt, p + 1);
    chk("R11 slow tick frame", {got_b9, got_data}, 9'h0A5);
    tdiv = 1;
    line_for(1'b1, 10);

    // R10 back-pressure
    set_ready(1'b0);
    p = got_cnt;
    d = done_cnt;
    send_frame(9'h13C, 1'b1, 1'b1, -1, 0);
    chk("R10 valid held", m_valid, 1);
    chk("R10 held frame", {m_bit9, m_data}, 9'h13C);
    chk("R10 done pulse", done_cnt, d + 1);
    send_frame(9'h0C3, 1'b1, 1'b1, -1, 0);
    chk("R10 second dropped", {m_bit9, m_data}, 9'h13C);
    chk("R10 no done on drop", done_cnt, d + 1);
    chk("R10 no transfer", got_cnt, p);
    set_ready(1'b1);
    @(negedge clk);
    chk("R10 transfer", got_cnt, p + 1);
    chk("R10 transferred frame", {got_b9, got_data}, 9'h13C);
    chk("R10 valid drops", m_valid, 0);

    // R8 and R9 break detection
    line_for(1'b1, 40);
    line_for(1'b0, 175);
    line_for(1'b1, 40);
    chk("R8 175 lows no break", brk_flag, 0);
    line_for(1'b0, 200);
    chk("R8 break set", brk_flag, 1);
    chk("R9 request masked", rst_req, 0);
    brk_rst_en = 1'b1;
    @(negedge clk);
    chk("R9 request raised", rst_req, 1);
    pulse_clr(1'b1);
    line_for(1'b0, 300);
    chk("R8 saturated low", brk_flag, 0);
    chk("R9 request gone", rst_req, 0);
    line_for(1'b1, 40);
    line_for(1'b0, 176);
    line_for(1'b1, 10);
    chk("R8 re-armed at 176", brk_flag, 1);
    brk_rst_en = 1'b0;
    line_for(1'b1, 200);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule